// File: doc/BRIEF.md
# Bus Line Deglitcher with Programmable Tick Divider

This block sits at the front of a two-wire serial bus controller. It divides the fast functional clock into a slower sampling rate, called the logic tick, and uses that rate to clean the clock and data lines before the protocol engine sees them. The tick is a one-cycle enable in the functional clock domain, so no derived clock is created. Its divide ratio comes from a 4-bit setting, and the ratio is the setting plus one.

Each raw bus line first passes through a two-stage synchronizer. The filter then samples it once per tick. A clean output moves to a new level only when two tick samples in a row agree on that level. As a result, any disturbance seen by one tick sample or none is thrown away. The widest spike that is rejected is one tick period, so the divide setting chooses that width directly. For example, with a 96 MHz functional clock and a setting of 3, the tick runs at 24 MHz and spikes of about 41.6 ns or less are removed, which meets a 50 ns noise budget. The same rule applies to both lines, each filtered on its own.

Top module: `scl_sda_deglitch`

## Requirements
- R1: During reset and on the first cycle after it, `tick` is 0 and both `scl_clean` and `sda_clean` are 1. Reset clears the tick counter to zero and loads the divide ratio from `div_sel`, so the first `tick` comes `div_sel`+1 cycles after reset is released.
- R2: `tick` is high for exactly one clock cycle, once every `div_sel`+1 clock cycles.
- R3: With `div_sel` = 0, `tick` is high on every cycle.
- R4: With `div_sel` = 15, `tick` is high once every 16 cycles.
- R5: A new `div_sel` value takes effect only when the counter wraps. The period already in progress finishes with the old ratio, so no shortened tick period ever occurs.
- R6: Each raw line is sampled through two synchronizer flops. The filter compares the synchronized level at each rising clock edge on which `tick` is high.
- R7: A clean output changes only on the edge that ends a cycle where `tick` is high. It takes the new level only when the current sample and the previous tick sample are equal and differ from the output.
- R8: A raw low pulse that lasts no longer than one tick period never appears on the clean output.
- R9: A raw low pulse that lasts at least two tick periods plus the synchronizer delay does appear on the clean output.
- R10: The two lines are filtered independently. Activity on one line never changes the other clean output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 4 | Divide setting; tick ratio is value + 1 |
| scl_raw | input | 1 | Raw bus clock line |
| sda_raw | input | 1 | Raw bus data line |
| tick | output | 1 | One-cycle logic tick enable |
| scl_clean | output | 1 | Filtered bus clock level |
| sda_clean | output | 1 | Filtered bus data level |

## Verification
The bench builds the block with its default 4-bit divide width and two synchronizer stages. This lets it cover the whole setting range, from a tick on every cycle up to a ratio of 16, and it changes the setting partway through a period. Pulses shorter than one tick period and longer than two periods are driven at several ratios to probe both sides of the rejection window. Pseudo-random activity on both lines at once exercises the independence of the two filters.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;
  localparam int NLINES   = 2;
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam logic IDLE_LEVEL = 1'b1;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // ratio is latched only at wrap so a period is never cut short
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      lim  <= div_sel;
      tick <= 1'b0;
    end else if (cnt == lim) begin
      cnt  <= '0;
      lim  <= div_sel;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{INIT}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tick_filter.sv
module tick_filter #(
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic dout
);
  logic last_smp;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_smp <= INIT;
      dout     <= INIT;
    end else if (tick) begin
      last_smp <= din;
      if (din == last_smp && din != dout) dout <= din;
    end
  end
endmodule

// File: rtl/scl_sda_deglitch.sv
module scl_sda_deglitch #(
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             scl_raw,
  input  logic             sda_raw,
  output logic             tick,
  output logic             scl_clean,
  output logic             sda_clean
);
  import deglitch_pkg::*;

  logic [NLINES-1:0] raw_v;
  logic [NLINES-1:0] sync_v;
  logic [NLINES-1:0] clean_v;

  assign raw_v[LINE_SCL] = scl_raw;
  assign raw_v[LINE_SDA] = sda_raw;

  tick_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .div_sel (div_sel),
    .tick    (tick)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    bit_sync #(.STAGES(SYNC_STAGES), .INIT(IDLE_LEVEL)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_v[i]),
      .dout (sync_v[i])
    );
    tick_filter #(.INIT(IDLE_LEVEL)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .tick (tick),
      .din  (sync_v[i]),
      .dout (clean_v[i])
    );
  end

  assign scl_clean = clean_v[LINE_SCL];
  assign sda_clean = clean_v[LINE_SDA];
endmodule

// File: rtl/deglitch_chk.sv
module deglitch_chk #(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] div_sel,
  input logic             tick,
  input logic             scl_clean,
  input logic             sda_clean
);
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] per;
  logic [DIV_W:0]   gap;
  logic             seen;

  always_ff @(posedge clk) begin
    div_d <= div_sel;
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
      per  <= '0;
    end else if (tick) begin
      gap  <= 1;
      seen <= 1'b1;
      per  <= div_d;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!tick && scl_clean && sda_clean));

  // R2
  tick_period_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && seen) |-> (gap == ({1'b0, per} + 1'b1)));

  // R7
  scl_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(scl_clean) |-> $past(tick));

  // R7
  sda_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_clean) |-> $past(tick));
endmodule

bind scl_sda_deglitch deglitch_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .div_sel   (div_sel),
  .tick      (tick),
  .scl_clean (scl_clean),
  .sda_clean (sda_clean)
);

// File: tb/scl_sda_deglitch_test.sv
module scl_sda_deglitch_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] div_sel = 4'd3;
  logic       scl_raw = 1'b1;
  logic       sda_raw = 1'b1;
  logic       tick, scl_clean, sda_clean;

  int vectors = 0;
  int errs    = 0;
  bit done    = 0;

  scl_sda_deglitch uut (
    .clk(clk), .rst(rst), .div_sel(div_sel),
    .scl_raw(scl_raw), .sda_raw(sda_raw),
    .tick(tick), .scl_clean(scl_clean), .sda_clean(sda_clean)
  );

  always #5 clk = ~clk;

  // behavioural reference
  int   m_cnt, m_lim;
  bit   m_tick = 0, m_scl = 1, m_sda = 1, m_pscl = 1, m_psda = 1;
  bit   q_scl[$] = '{1, 1};
  bit   q_sda[$] = '{1, 1};

  always @(posedge clk) begin
    bit vs, vd, old_tick;
    old_tick = m_tick;
    if (rst) begin
      m_cnt = 0; m_lim = div_sel; m_tick = 0;
      m_scl = 1; m_sda = 1; m_pscl = 1; m_psda = 1;
      q_scl = '{1, 1}; q_sda = '{1, 1};
    end else begin
      vs = q_scl.pop_front(); q_scl.push_back(scl_raw);
      vd = q_sda.pop_front(); q_sda.push_back(sda_raw);
      if (old_tick) begin
        if (vs == m_pscl) m_scl = vs;
        if (vd == m_psda) m_sda = vd;
        m_pscl = vs; m_psda = vd;
      end
      if (m_cnt == m_lim) begin
        m_cnt = 0; m_lim = div_sel; m_tick = 1;
      end else begin
        m_cnt++; m_tick = 0;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(tick == m_tick, "R2 tick", tick, m_tick);
      check(scl_clean == m_scl, "R7 scl_clean", scl_clean, m_scl);
      check(sda_clean == m_sda, "R10 sda_clean", sda_clean, m_sda);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  // count ticks over a window
  task automatic count_ticks(int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); #1; if (tick) c++; end
  endtask

  // low pulse on scl, report whether scl_clean ever dropped
  task automatic scl_pulse(int len, output bit dropped);
    dropped = 0;
    @(negedge clk); scl_raw = 0;
    repeat (len) begin @(negedge clk); #1; if (!scl_clean) dropped = 1; end
    scl_raw = 1;
    repeat (40) begin @(negedge clk); #1; if (!scl_clean) dropped = 1; end
  endtask

  initial begin
    int c;
    bit d;
    logic [15:0] lfsr = 16'hACE1;
    cycles(3);
    // R1 reset state
    check(tick == 0, "R1 tick in reset", tick, 0);
    check(scl_clean == 1 && sda_clean == 1, "R1 lines idle", {scl_clean, sda_clean}, 3);
    rst = 0;
    @(negedge clk);
    check(tick == 0, "R1 tick after release", tick, 0);
    cycles(3); #1;
    check(tick == 1, "R1 first tick at ratio 4", tick, 1);

    // R2 ratio 4
    count_ticks(40, c);
    check(c == 10, "R2 ticks per 40 cycles at setting 3", c, 10);
    // R3 setting 0
    div_sel = 0; cycles(8);
    count_ticks(20, c);
    check(c == 20, "R3 tick every cycle", c, 20);
    // R4 setting 15
    div_sel = 15; cycles(20);
    count_ticks(64, c);
    check(c == 4, "R4 ratio 16", c, 4);

    // R5 change mid-period: wait for a tick, then change two cycles later
    while (!tick) begin @(negedge clk); #1; end
    cycles(2); div_sel = 1;
    c = 0;
    while (!tick) begin @(negedge clk); #1; c++; end
    check(c == 14, "R5 old ratio finishes", c, 14);
    c = 0;
    do begin @(negedge clk); #1; c++; end while (!tick);
    check(c == 2, "R5 new ratio after wrap", c, 2);

    // R8/R9 window at ratio 4 and 8
    div_sel = 3; cycles(20);
    scl_pulse(4, d);
    check(d == 0, "R8 4-cycle spike rejected at ratio 4", d, 0);
    scl_pulse(3, d);
    check(d == 0, "R8 3-cycle spike rejected at ratio 4", d, 0);
    scl_pulse(12, d);
    check(d == 1, "R9 12-cycle pulse passes at ratio 4", d, 1);
    div_sel = 7; cycles(20);
    scl_pulse(8, d);
    check(d == 0, "R8 8-cycle spike rejected at ratio 8", d, 0);
    scl_pulse(20, d);
    check(d == 1, "R9 20-cycle pulse passes at ratio 8", d, 1);
    div_sel = 0; cycles(10);
    scl_pulse(1, d);
    check(d == 0, "R8 1-cycle spike rejected at ratio 1", d, 0);

    // R10 sda held low while scl toggles
    div_sel = 2; cycles(10);
    sda_raw = 0; cycles(30); #1;
    check(sda_clean == 0, "R10 sda settles low", sda_clean, 0);
    repeat (10) begin scl_raw = ~scl_raw; cycles(13); #1;
      check(sda_clean == 0, "R10 sda unaffected by scl", sda_clean, 0); end
    scl_raw = 1; sda_raw = 1;

    // R6/R7 pseudo-random activity on both lines at several ratios
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 0) scl_raw = ~scl_raw;
      if (lfsr[7:4] == 0) sda_raw = ~sda_raw;
      if (k % 500 == 0) div_sel = lfsr[11:8];
    end

    // R1 reset mid-run
    @(negedge clk); rst = 1; cycles(2); rst = 0;
    @(negedge clk); #1;
    check(scl_clean && sda_clean && !tick, "R1 re-reset idle", {scl_clean, sda_clean, tick}, 6);
    cycles(20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #1500000;
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule